// File: doc/BRIEF.md
# Set-Associative Read-Only Load Cache with LRU Replacement

This block is a small cache for 32-bit word loads. It sits between a processor-side load port and a slower backing memory. Three parameters set its geometry: capacity in words, block size in words, and number of ways. The block count is the capacity divided by the block size. The set count is the block count divided by the number of ways. One way gives a direct-mapped cache, and a way count equal to the block count gives a single fully associative set. The main targets are an eight-word cache with one-word blocks, built either direct-mapped or two-way.

A load is accepted when the request line is high and the stall output is low. The address is a byte address. Its two lowest bits are ignored. The next bits pick the word inside a block, the bits above those pick the set, and the remaining upper bits form the tag. A hit returns the word in the next cycle. A miss raises the stall output and sends a one-cycle request for the whole block to backing memory. It then waits for the response and writes the block into a way of the indexed set. An invalid way is used first; otherwise the least recently used way is replaced. The requested word is returned from the filled block. Two counters report accepted loads and misses, so that exact hit and miss rates can be checked on scripted access streams.

Top module: `assoc_rd_cache`

## Requirements
- R1: Address split. Byte address bits [1:0] are ignored. The next log2(BLK_WORDS) bits select the word in the block, and the next log2(sets) bits select the set, where sets = CAP_WORDS / BLK_WORDS / NUM_WAYS. The rest of the address is the tag. Word k of a block sits in bits [32k+31:32k] of the memory response.
- R2: While reset is high and after it is released, no line is valid, both counters read 0, and ld_stall, ld_done and mem_req are low. The first load after reset therefore misses.
- R3: A load accepted while ld_stall is low that hits is answered in the following cycle: ld_done is 1 with the addressed word, ld_stall stays 0, and mem_req stays 0.
- R4: A load that misses makes ld_stall and mem_req 1 in the following cycle. mem_req lasts exactly one cycle, and mem_addr is the byte address of the block start, with the low log2(BLK_WORDS)+2 bits zero.
- R5: In the cycle after mem_rsp_valid is sampled while stalled, ld_done is 1 with the requested word taken from the response block, and ld_stall returns to 0. The block then hits on later loads.
- R6: A fill uses the lowest-numbered invalid way of the set. If the set is full, the fill replaces the least recently used way. Every hit and every fill makes its way the most recent. In the two-way build this state is one bit per set.
- R7: acc_count rises by one for each accepted load, and miss_count rises by one for each accepted load that misses. Both are visible in the cycle after acceptance, and both saturate at their maximum.
- R8: With eight words, one-word blocks and one way, ten alternating loads of 0x4 and 0x24 all miss. With two ways, only the first two miss.
- R9: Five passes over 0x4, 0xC, 0x8 give 3 misses in 15 loads with one-word blocks, and 1 miss with four-word blocks.
- R10: ld_req while ld_stall is high has no effect. The counters do not change, no request is issued, and the outstanding load still returns its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Load request, accepted when ld_stall is low |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_stall | output | 1 | High while a miss is being filled |
| ld_done | output | 1 | One-cycle pulse: ld_data holds the loaded word |
| ld_data | output | 32 | Loaded word |
| mem_req | output | 1 | One-cycle block fetch request |
| mem_addr | output | ADDR_W | Block-aligned byte address of the fetch |
| mem_rsp_valid | input | 1 | Backing memory returns the block this cycle |
| mem_rsp_data | input | BLK_WORDS*32 | Fetched block, word k in bits [32k+31:32k] |
| acc_count | output | CNT_W | Accepted loads since reset |
| miss_count | output | CNT_W | Accepted misses since reset |

## Verification
The bench runs four geometries side by side: direct-mapped, two-way, four-word blocks and a four-way single set. It checks each against a recency-list model on the conflict stream, the looping stream, a targeted eviction order and a pseudo-random stream with nonzero byte offsets. A design that evicts the most recent way, or that skips the LRU update on hits, would miss on the re-read of 0x4 in the eviction sequence and change the miss totals. A wrong set or word split would return the wrong word or the wrong miss counts for the four-word build. A cache that accepted a request while stalled would bump the access counter or fetch the injected address.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_OFS = 2;

    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } fsm_e;

    // address bits needed to pick one of n items (0 when n is 1)
    function automatic int bits_of(input int n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

    // signal width for an index into n items (at least 1)
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rdc_tag_store.sv
module rdc_tag_store
    import rdc_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 2,
    parameter int TAG_W    = 28,
    parameter int LINE_W   = 32,
    parameter int IXSW     = 2,
    parameter int WYSW     = 1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic [IXSW-1:0]     rd_set,
    input  logic [TAG_W-1:0]    rd_tag,
    output logic [NUM_WAYS-1:0] hit_vec,
    output logic [NUM_WAYS-1:0] valid_vec,
    output logic [LINE_W-1:0]   hit_line,
    input  logic                wr_en,
    input  logic [IXSW-1:0]     wr_set,
    input  logic [WYSW-1:0]     wr_way,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [LINE_W-1:0]   wr_line
);
    localparam int NSLOT = 1 << IXSW;

    logic [NUM_WAYS-1:0] vld   [NSLOT];
    logic [TAG_W-1:0]    tags  [NSLOT][NUM_WAYS];
    logic [LINE_W-1:0]   lines [NSLOT][NUM_WAYS];
    logic [LINE_W-1:0]   masked [NUM_WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSLOT; s++) vld[s] <= '0;
        end else if (wr_en) begin
            vld[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_set][wr_way]  <= wr_tag;
            lines[wr_set][wr_way] <= wr_line;
        end
    end

    assign valid_vec = vld[rd_set];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign hit_vec[w] = vld[rd_set][w] && (tags[rd_set][w] == rd_tag);
        assign masked[w]  = hit_vec[w] ? lines[rd_set][w] : '0;
    end

    always_comb begin
        hit_line = '0;
        for (int w = 0; w < NUM_WAYS; w++) hit_line = hit_line | masked[w];
    end

    // a block may live in at most one way of its set
    assert_single_hit_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
endmodule

// File: rtl/rdc_lru.sv
module rdc_lru
    import rdc_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 2,
    parameter int IXSW     = 2,
    parameter int WYSW     = 1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                touch_en,
    input  logic [IXSW-1:0]     touch_set,
    input  logic [WYSW-1:0]     touch_way,
    input  logic [IXSW-1:0]     vic_set,
    input  logic [NUM_WAYS-1:0] valid_vec,
    output logic [WYSW-1:0]     victim
);
    localparam int NSLOT = 1 << IXSW;

    logic [WYSW-1:0] lru_way;
    logic [WYSW-1:0] first_free;
    logic            any_free;

    always_comb begin
        any_free   = 1'b0;
        first_free = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                any_free   = 1'b1;
                first_free = WYSW'(w);
            end
        end
    end

    assign victim = any_free ? first_free : lru_way;

    if (NUM_WAYS == 1) begin : g_one
        assign lru_way = '0;
    end else if (NUM_WAYS == 2) begin : g_bit
        // per set: index of the way used least recently
        logic old_way [NSLOT];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < NSLOT; s++) old_way[s] <= 1'b0;
            end else if (touch_en) begin
                old_way[touch_set] <= ~touch_way[0];
            end
        end
        assign lru_way = WYSW'(old_way[vic_set]);

        assert_lru_flip_R6: assert property (@(posedge clk) disable iff (rst)
            touch_en |=> (old_way[$past(touch_set)] != $past(touch_way[0])));
    end else begin : g_age
        // per way recency rank, 0 = most recent
        logic [WYSW-1:0] age [NSLOT][NUM_WAYS];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < NSLOT; s++)
                    for (int w = 0; w < NUM_WAYS; w++) age[s][w] <= WYSW'(w);
            end else if (touch_en) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if (WYSW'(w) == touch_way)
                        age[touch_set][w] <= '0;
                    else if (age[touch_set][w] < age[touch_set][touch_way])
                        age[touch_set][w] <= age[touch_set][w] + 1'b1;
                end
            end
        end
        always_comb begin
            lru_way = '0;
            for (int w = 0; w < NUM_WAYS; w++)
                if (age[vic_set][w] == WYSW'(NUM_WAYS - 1)) lru_way = WYSW'(w);
        end

        assert_touch_newest_R6: assert property (@(posedge clk) disable iff (rst)
            touch_en |=> (age[$past(touch_set)][$past(touch_way)] == '0));
    end
endmodule

// File: rtl/rdc_stats.sv
module rdc_stats #(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_acc,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] acc_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_count  <= '0;
            miss_count <= '0;
        end else begin
            if (inc_acc && acc_count != CNT_MAX)   acc_count  <= acc_count + 1'b1;
            if (inc_miss && miss_count != CNT_MAX) miss_count <= miss_count + 1'b1;
        end
    end

    assert_miss_le_acc_R7: assert property (@(posedge clk) disable iff (rst)
        miss_count <= acc_count);
endmodule

// File: rtl/assoc_rd_cache.sv
module assoc_rd_cache
    import rdc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CAP_WORDS = 8,
    parameter int BLK_WORDS = 1,
    parameter int NUM_WAYS  = 2,
    parameter int CNT_W     = 16
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_req,
    input  logic [ADDR_W-1:0]         ld_addr,
    output logic                      ld_stall,
    output logic                      ld_done,
    output logic [WORD_W-1:0]         ld_data,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_rsp_valid,
    input  logic [BLK_WORDS*WORD_W-1:0] mem_rsp_data,
    output logic [CNT_W-1:0]          acc_count,
    output logic [CNT_W-1:0]          miss_count
);
    localparam int NUM_BLKS = CAP_WORDS / BLK_WORDS;
    localparam int NUM_SETS = NUM_BLKS / NUM_WAYS;
    localparam int BO_W     = bits_of(BLK_WORDS);
    localparam int IX_W     = bits_of(NUM_SETS);
    localparam int TAG_W    = ADDR_W - BYTE_OFS - BO_W - IX_W;
    localparam int BOSW     = idx_w(BLK_WORDS);
    localparam int IXSW     = idx_w(NUM_SETS);
    localparam int WYSW     = idx_w(NUM_WAYS);
    localparam int LINE_W   = BLK_WORDS * WORD_W;
    localparam int ALIGN_SH = BYTE_OFS + BO_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IXSW-1:0]  set;
        logic [BOSW-1:0]  word;
    } fields_t;

    function automatic fields_t split(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] wa;
        fields_t f;
        wa     = a >> BYTE_OFS;
        f.word = BOSW'(wa % ADDR_W'(BLK_WORDS));
        f.set  = IXSW'((wa / ADDR_W'(BLK_WORDS)) % ADDR_W'(NUM_SETS));
        f.tag  = TAG_W'(wa / ADDR_W'(BLK_WORDS * NUM_SETS));
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] line,
                                               input logic [BOSW-1:0] w);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int k = 0; k < BLK_WORDS; k++)
            if (w == BOSW'(k)) r = line[k*WORD_W +: WORD_W];
        return r;
    endfunction

    fsm_e                state;
    fields_t             req_f, pend_f;
    logic [NUM_WAYS-1:0] hit_vec, valid_vec;
    logic [LINE_W-1:0]   hit_line;
    logic                hit, accept, fill, touch_en;
    logic [WYSW-1:0]     hit_idx, victim, touch_way;
    logic [IXSW-1:0]     look_set, touch_set;

    assign req_f    = split(ld_addr);
    assign ld_stall = (state == ST_FILL);
    assign accept   = ld_req && (state == ST_LOOKUP);
    assign fill     = (state == ST_FILL) && mem_rsp_valid;
    assign look_set = (state == ST_FILL) ? pend_f.set : req_f.set;
    assign hit      = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < NUM_WAYS; w++) if (hit_vec[w]) hit_idx = WYSW'(w);
    end

    assign touch_en  = (accept && hit) || fill;
    assign touch_set = fill ? pend_f.set : req_f.set;
    assign touch_way = fill ? victim : hit_idx;

    rdc_tag_store #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W),
        .LINE_W(LINE_W), .IXSW(IXSW), .WYSW(WYSW)
    ) u_store (
        .clk(clk), .rst(rst),
        .rd_set(look_set), .rd_tag(req_f.tag),
        .hit_vec(hit_vec), .valid_vec(valid_vec), .hit_line(hit_line),
        .wr_en(fill), .wr_set(pend_f.set), .wr_way(victim),
        .wr_tag(pend_f.tag), .wr_line(mem_rsp_data)
    );

    rdc_lru #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .IXSW(IXSW), .WYSW(WYSW)
    ) u_lru (
        .clk(clk), .rst(rst),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
        .vic_set(pend_f.set), .valid_vec(valid_vec), .victim(victim)
    );

    rdc_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst(rst),
        .inc_acc(accept), .inc_miss(accept && !hit),
        .acc_count(acc_count), .miss_count(miss_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_LOOKUP;
            ld_done  <= 1'b0;
            ld_data  <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            pend_f   <= '0;
        end else begin
            ld_done <= 1'b0;
            mem_req <= 1'b0;
            case (state)
                ST_LOOKUP: begin
                    if (accept) begin
                        if (hit) begin
                            ld_done <= 1'b1;
                            ld_data <= pick(hit_line, req_f.word);
                        end else begin
                            state    <= ST_FILL;
                            mem_req  <= 1'b1;
                            pend_f   <= req_f;
                            mem_addr <= (ld_addr >> ALIGN_SH) << ALIGN_SH;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        state   <= ST_LOOKUP;
                        ld_done <= 1'b1;
                        ld_data <= pick(mem_rsp_data, pend_f.word);
                    end
                end
                default: state <= ST_LOOKUP;
            endcase
        end
    end

    assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> (ld_done && !ld_stall && !mem_req));
    assert_miss_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit) |=> (ld_stall && mem_req));
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    assert_fill_return_R5: assert property (@(posedge clk) disable iff (rst)
        fill |=> (ld_done && !ld_stall));
    assert_stall_ignores_R10: assert property (@(posedge clk) disable iff (rst)
        (ld_stall && !mem_rsp_valid) |=> ($stable(acc_count) && ld_stall && !mem_req));
endmodule

// File: tb/tb_assoc_rd_cache.sv
`timescale 1ns/1ps
module tb_assoc_rd_cache;
    localparam int NI  = 4;
    localparam int LAT = 3;
    // geometries: 0 two-way, 1 direct-mapped, 2 four-word blocks, 3 four-way single set
    localparam int G_BLK  [NI] = '{1, 1, 4, 1};
    localparam int G_SETS [NI] = '{4, 8, 2, 1};
    localparam int G_WAYS [NI] = '{2, 1, 1, 4};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_req = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        stall [NI];
    logic        done  [NI];
    logic [31:0] data  [NI];
    logic        mreq  [NI];
    logic [31:0] maddr [NI];
    logic        rv    [NI];
    logic [127:0] rdat [NI];
    logic [15:0] acc   [NI];
    logic [15:0] miss  [NI];

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    assoc_rd_cache #(.CAP_WORDS(8), .BLK_WORDS(1), .NUM_WAYS(2)) dut (
        .clk(clk), .rst(rst), .ld_req(ld_req), .ld_addr(ld_addr),
        .ld_stall(stall[0]), .ld_done(done[0]), .ld_data(data[0]),
        .mem_req(mreq[0]), .mem_addr(maddr[0]), .mem_rsp_valid(rv[0]),
        .mem_rsp_data(rdat[0][31:0]), .acc_count(acc[0]), .miss_count(miss[0]));
    assoc_rd_cache #(.CAP_WORDS(8), .BLK_WORDS(1), .NUM_WAYS(1)) dut_dm (
        .clk(clk), .rst(rst), .ld_req(ld_req), .ld_addr(ld_addr),
        .ld_stall(stall[1]), .ld_done(done[1]), .ld_data(data[1]),
        .mem_req(mreq[1]), .mem_addr(maddr[1]), .mem_rsp_valid(rv[1]),
        .mem_rsp_data(rdat[1][31:0]), .acc_count(acc[1]), .miss_count(miss[1]));
    assoc_rd_cache #(.CAP_WORDS(8), .BLK_WORDS(4), .NUM_WAYS(1)) dut_b4 (
        .clk(clk), .rst(rst), .ld_req(ld_req), .ld_addr(ld_addr),
        .ld_stall(stall[2]), .ld_done(done[2]), .ld_data(data[2]),
        .mem_req(mreq[2]), .mem_addr(maddr[2]), .mem_rsp_valid(rv[2]),
        .mem_rsp_data(rdat[2]), .acc_count(acc[2]), .miss_count(miss[2]));
    assoc_rd_cache #(.CAP_WORDS(4), .BLK_WORDS(1), .NUM_WAYS(4)) dut_fa (
        .clk(clk), .rst(rst), .ld_req(ld_req), .ld_addr(ld_addr),
        .ld_stall(stall[3]), .ld_done(done[3]), .ld_data(data[3]),
        .mem_req(mreq[3]), .mem_addr(maddr[3]), .mem_rsp_valid(rv[3]),
        .mem_rsp_data(rdat[3][31:0]), .acc_count(acc[3]), .miss_count(miss[3]));

    function automatic logic [31:0] memw(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    // fixed-latency backing memory, one per instance, driven away from the active edge
    int cd [NI];
    always @(negedge clk) begin
        for (int i = 0; i < NI; i++) begin
            rv[i] = 1'b0;
            if (rst) cd[i] = 0;
            else if (mreq[i]) begin
                cd[i] = LAT;
                for (int k = 0; k < 4; k++) rdat[i][32*k +: 32] = memw(maddr[i] + 32'(4*k));
            end else if (cd[i] > 0) begin
                cd[i]--;
                if (cd[i] == 0) rv[i] = 1'b1;
            end
        end
    end

    // reference model: per set a list of block numbers, most recent first
    int ent [NI][8][8];
    int cnt [NI][8];
    int m_acc [NI];
    int m_miss [NI];

    function automatic bit model_access(input int i, input logic [31:0] a);
        int blk, set, pos, n;
        blk = int'(a >> 2) / G_BLK[i];
        set = blk % G_SETS[i];
        pos = -1;
        for (int k = 0; k < cnt[i][set]; k++) if (ent[i][set][k] == blk) pos = k;
        if (pos >= 0) begin
            for (int k = pos; k > 0; k--) ent[i][set][k] = ent[i][set][k-1];
            ent[i][set][0] = blk;
            return 1'b1;
        end
        n = (cnt[i][set] < G_WAYS[i]) ? cnt[i][set] + 1 : G_WAYS[i];
        cnt[i][set] = n;
        for (int k = n - 1; k > 0; k--) ent[i][set][k] = ent[i][set][k-1];
        ent[i][set][0] = blk;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string what, input int inst,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s inst %0d: actual=%0h expected=%0h", what, inst, act, exp);
        end
    endtask

    task automatic chk_counts(input string what);
        for (int i = 0; i < NI; i++) begin
            chk(acc[i] == 16'(m_acc[i]), {what, " R7 acc_count"}, i, acc[i], m_acc[i]);
            chk(miss[i] == 16'(m_miss[i]), {what, " R7 miss_count"}, i, miss[i], m_miss[i]);
        end
    endtask

    task automatic do_reset();
        ld_req = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            chk(!stall[i] && !done[i] && !mreq[i], "R2 outputs held in reset", i,
                {stall[i], done[i], mreq[i]}, 0);
        end
        rst = 1'b0;
        for (int i = 0; i < NI; i++) begin
            m_acc[i] = 0;
            m_miss[i] = 0;
            for (int s = 0; s < 8; s++) cnt[i][s] = 0;
        end
        @(negedge clk);
        for (int i = 0; i < NI; i++)
            chk(!stall[i] && !done[i] && !mreq[i], "R2 idle after reset", i,
                {stall[i], done[i], mreq[i]}, 0);
        chk_counts("R2 reset");
    endtask

    // issue one load at a falling edge; optional stray request during the stall
    task automatic do_load(input logic [31:0] a, input bit inject);
        bit exp_hit [NI];
        bit got [NI];
        bit all;
        int waited;
        logic [31:0] expw;
        expw = memw(a & ~32'h3);
        ld_req = 1'b1;
        ld_addr = a;
        for (int i = 0; i < NI; i++) begin
            exp_hit[i] = model_access(i, a);
            m_acc[i]++;
            if (!exp_hit[i]) m_miss[i]++;
        end
        @(negedge clk);
        ld_req = 1'b0;
        for (int i = 0; i < NI; i++) begin
            got[i] = 1'b0;
            if (exp_hit[i]) begin
                chk(done[i] && !stall[i] && !mreq[i], "R3 hit answered next cycle R6/R1", i,
                    {done[i], stall[i], mreq[i]}, 3'b100);
                chk(data[i] == expw, "R3 hit data R1", i, data[i], expw);
                got[i] = 1'b1;
            end else begin
                chk(stall[i] && mreq[i] && !done[i], "R4 miss stalls and requests R6/R1", i,
                    {done[i], stall[i], mreq[i]}, 3'b011);
                chk(maddr[i] == (a & ~32'(G_BLK[i]*4 - 1)), "R4 block-aligned mem_addr", i,
                    maddr[i], a & ~32'(G_BLK[i]*4 - 1));
            end
        end
        chk_counts("after accept");
        if (inject) begin
            ld_req = 1'b1;
            ld_addr = 32'h200;
        end
        waited = 0;
        all = 1'b1;
        for (int i = 0; i < NI; i++) all = all && got[i];
        while (!all && waited < 50) begin
            @(negedge clk);
            ld_req = 1'b0;
            waited++;
            for (int i = 0; i < NI; i++) begin
                if (!got[i]) begin
                    if (done[i]) begin
                        chk(!stall[i], "R5 stall released with data", i, stall[i], 0);
                        chk(data[i] == expw, "R5 fill data word select R10", i, data[i], expw);
                        got[i] = 1'b1;
                    end else begin
                        chk(!mreq[i], "R4 single request pulse R10", i, mreq[i], 0);
                    end
                end
            end
            chk_counts("during fill R10");
            all = 1'b1;
            for (int i = 0; i < NI; i++) all = all && got[i];
        end
        chk(all, "load completion", 0, waited, LAT + 1);
    endtask

    int base_m [NI];
    logic [31:0] lf;

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2 first access misses; R10 stray request during the stall is ignored
        do_load(32'h100, 1'b1);
        for (int i = 0; i < NI; i++) chk(miss[i] == 16'd1, "R2 first load misses", i, miss[i], 1);
        do_load(32'h200, 1'b0);
        for (int i = 0; i < NI; i++)
            chk(miss[i] == 16'd2 && acc[i] == 16'd2, "R10 stray address not fetched", i,
                {acc[i], miss[i]}, {16'd2, 16'd2});

        // R8 conflict stream
        do_reset();
        for (int r = 0; r < 5; r++) begin
            do_load(32'h4, 1'b0);
            do_load(32'h24, 1'b0);
        end
        chk(miss[0] == 16'd2, "R8 two-way misses", 0, miss[0], 2);
        chk(miss[1] == 16'd10, "R8 direct-mapped misses", 1, miss[1], 10);
        chk(acc[1] == 16'd10, "R8 access count", 1, acc[1], 10);

        // R9 looping stream
        do_reset();
        for (int r = 0; r < 5; r++) begin
            do_load(32'h4, 1'b0);
            do_load(32'hC, 1'b0);
            do_load(32'h8, 1'b0);
        end
        chk(miss[1] == 16'd3, "R9 one-word blocks misses", 1, miss[1], 3);
        chk(miss[2] == 16'd1, "R9 four-word blocks misses", 2, miss[2], 1);
        chk(acc[2] == 16'd15, "R9 access count", 2, acc[2], 15);

        // R6 eviction order in set 1 of the two-way build
        do_reset();
        do_load(32'h4, 1'b0);
        do_load(32'h24, 1'b0);
        do_load(32'h4, 1'b0);
        base_m[0] = miss[0];
        do_load(32'h44, 1'b0);
        do_load(32'h4, 1'b0);
        chk(miss[0] == 16'(base_m[0] + 1), "R6 recently hit way kept", 0, miss[0], base_m[0] + 1);
        do_load(32'h24, 1'b0);
        chk(miss[0] == 16'(base_m[0] + 2), "R6 LRU way evicted", 0, miss[0], base_m[0] + 2);

        // R1 pseudo-random stream with nonzero byte offsets
        do_reset();
        lf = 32'hACE1;
        for (int n = 0; n < 64; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            do_load({25'd0, lf[6:0]}, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule